// File: doc/BRIEF.md
# Time-Redundant Memory Write Voter

This block sits on the write path between one processor and its main memory. A processor write never goes straight to memory while voting is active. The block keeps it, withholds it from memory and asks the processor to roll back to its last checkpoint. When the processor runs the same slice of code again and arrives at the same write, the block compares the new address/data pair with the kept one. If the two agree, the block commits the write and emits a checkpoint strobe, which lets the processor save a new safe state.

If the second pass disagrees with the first, the block keeps the second pair too and requests one more rollback. On the third pass it writes whichever pair two of the three passes agree on. If all three passes differ, it raises a sticky error that halts the processor until reset. Before the program leaves its boot region there is no redundancy to apply, so writes go straight through.

Top module: `wr_vote_top`

## Requirements
- R1: After reset, memWrEn, rollbackReq, checkpoint, mismatch and errHalt are all low.
- R2: A write accepted in the first-pass state while userMode is high produces no memory write. Instead, rollbackReq pulses high for one cycle, one clock after the request.
- R3: In the second pass, a write whose address and data both equal the first-pass pair drives memWrEn high for one cycle, one clock after the request, with that pair on memAddr/memData. checkpoint pulses high in the same cycle.
- R4: In the second pass, a write that differs from the first-pass pair in the address, the data or both produces no memory write. mismatch and rollbackReq both pulse high for one cycle.
- R5: In the third pass, a write whose pair equals either earlier pair is committed as one memWrEn pulse carrying that pair, together with a checkpoint pulse.
- R6: In the third pass, a write whose pair equals neither earlier pair sets errHalt. errHalt stays high until reset, and while it is high every further write is ignored: no memWrEn, no rollbackReq and no checkpoint.
- R7: A write in the first-pass state while userMode is low is passed to memory one clock later as a single memWrEn pulse. No rollback and no checkpoint are issued.
- R8: userMode is sampled only in the first-pass state. Once a slice is under vote, later passes are voted even if userMode has dropped. After every commit the block returns to the first-pass state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| userMode | input | 1 | High once execution is in the user program region; enables voting |
| procWrEn | input | 1 | Processor write request, one cycle per write |
| procAddr | input | ADDR_W | Processor write address |
| procData | input | DATA_W | Processor write data |
| memWrEn | output | 1 | One-cycle memory write enable |
| memAddr | output | ADDR_W | Memory write address |
| memData | output | DATA_W | Memory write data |
| rollbackReq | output | 1 | One-cycle request to restore the last checkpoint |
| checkpoint | output | 1 | One-cycle strobe to save a new checkpoint |
| mismatch | output | 1 | One-cycle flag: second pass disagreed with the first |
| errHalt | output | 1 | Sticky error: three passes all disagreed |

## Verification
The hardest situations to reach from the ports are the third pass and the three-way disagreement. Both need the processor to produce different pairs for the same write on successive passes. The stimulus acts as a faulty processor: it corrupts the address or data of chosen passes and makes the third pass match either the first or the second pair. It also makes every pass differ, then checks that later writes are ignored until reset. A directed slice drops userMode in the middle of a vote, to show that the slice still needs agreement.

// File: rtl/wr_vote_pkg.sv
package wr_vote_pkg;
  typedef enum logic [1:0] {
    ST_FIRST  = 2'd0,
    ST_SECOND = 2'd1,
    ST_THIRD  = 2'd2,
    ST_HALT   = 2'd3
  } passState_t;

  localparam int NUM_SLOTS = 2;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] capSlot;
    logic                 commit;
  } dpStrobe_t;
endpackage

// File: rtl/wr_vote_dp.sv
module wr_vote_dp
  import wr_vote_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [NUM_SLOTS-1:0] slotMatch,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int PAIR_W = ADDR_W + DATA_W;

  logic [PAIR_W-1:0] inPair;
  assign inPair = {inAddr, inData};

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [PAIR_W-1:0] slotPair;
    always_ff @(posedge clk) begin
      if (!rstN)                  slotPair <= '0;
      else if (strobe.capSlot[s]) slotPair <= inPair;
    end
    // whole-pair equality: address and data must both agree
    assign slotMatch[s] = (slotPair == inPair);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strobe.commit;
      if (strobe.commit) begin
        memAddr <= inAddr;
        memData <= inData;
      end
    end
  end
endmodule

// File: rtl/wr_vote_ctl.sv
module wr_vote_ctl
  import wr_vote_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 procWrEn,
  input  logic                 userMode,
  input  logic [NUM_SLOTS-1:0] slotMatch,
  output dpStrobe_t            strobe,
  output passState_t           curState,
  output logic                 rollbackReq,
  output logic                 checkpoint,
  output logic                 mismatch,
  output logic                 errHalt
);
  passState_t nextState;
  logic rbNext, ckNext, misNext, haltNext;

  always_comb begin
    nextState = curState;
    strobe    = '0;
    rbNext    = 1'b0;
    ckNext    = 1'b0;
    misNext   = 1'b0;
    haltNext  = 1'b0;
    if (procWrEn) begin
      unique case (curState)
        ST_FIRST: begin
          if (userMode) begin
            strobe.capSlot[0] = 1'b1;
            rbNext            = 1'b1;
            nextState         = ST_SECOND;
          end else begin
            strobe.commit = 1'b1;
          end
        end
        ST_SECOND: begin
          if (slotMatch[0]) begin
            strobe.commit = 1'b1;
            ckNext        = 1'b1;
            nextState     = ST_FIRST;
          end else begin
            strobe.capSlot[1] = 1'b1;
            misNext           = 1'b1;
            rbNext            = 1'b1;
            nextState         = ST_THIRD;
          end
        end
        ST_THIRD: begin
          if (|slotMatch) begin
            strobe.commit = 1'b1;
            ckNext        = 1'b1;
            nextState     = ST_FIRST;
          end else begin
            haltNext  = 1'b1;
            nextState = ST_HALT;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curState    <= ST_FIRST;
      rollbackReq <= 1'b0;
      checkpoint  <= 1'b0;
      mismatch    <= 1'b0;
      errHalt     <= 1'b0;
    end else begin
      curState    <= nextState;
      rollbackReq <= rbNext;
      checkpoint  <= ckNext;
      mismatch    <= misNext;
      errHalt     <= errHalt | haltNext;
    end
  end
endmodule

// File: rtl/wr_vote_top.sv
module wr_vote_top
  import wr_vote_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              userMode,
  input  logic              procWrEn,
  input  logic [ADDR_W-1:0] procAddr,
  input  logic [DATA_W-1:0] procData,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              rollbackReq,
  output logic              checkpoint,
  output logic              mismatch,
  output logic              errHalt
);
  dpStrobe_t            strobe;
  logic [NUM_SLOTS-1:0] slotMatch;
  passState_t           curState;

  wr_vote_ctl i_ctl (
    .clk(clk), .rstN(rstN), .procWrEn(procWrEn), .userMode(userMode),
    .slotMatch(slotMatch), .strobe(strobe), .curState(curState),
    .rollbackReq(rollbackReq), .checkpoint(checkpoint),
    .mismatch(mismatch), .errHalt(errHalt)
  );

  wr_vote_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(procAddr),
    .inData(procData), .slotMatch(slotMatch), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/wr_vote_chk.sv
module wr_vote_chk
  import wr_vote_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       userMode,
  input logic       procWrEn,
  input logic       memWrEn,
  input logic       rollbackReq,
  input logic       checkpoint,
  input logic       mismatch,
  input logic       errHalt,
  input passState_t curState
);
  AST_FIRST_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_FIRST && procWrEn && userMode) |=> (rollbackReq && !memWrEn)); // R2
  AST_CKPT_HAS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    checkpoint |-> memWrEn); // R3
  AST_MISMATCH_ROLLS: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |-> (rollbackReq && !memWrEn)); // R4
  AST_WRITE_NOT_ROLL: assert property (@(posedge clk) disable iff (!rstN)
    !(memWrEn && rollbackReq)); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    errHalt |=> errHalt); // R6
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (errHalt && $past(errHalt)) |-> (!memWrEn && !rollbackReq && !checkpoint)); // R6
  AST_BOOT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_FIRST && procWrEn && !userMode) |=> (memWrEn && !checkpoint && !rollbackReq)); // R7
endmodule

bind wr_vote_top wr_vote_chk i_chk (
  .clk(clk), .rstN(rstN), .userMode(userMode), .procWrEn(procWrEn),
  .memWrEn(memWrEn), .rollbackReq(rollbackReq), .checkpoint(checkpoint),
  .mismatch(mismatch), .errHalt(errHalt), .curState(curState)
);

// File: tb/test_wr_vote_top.sv
module test_wr_vote_top;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic userMode = 1'b0;
  logic procWrEn = 1'b0;
  logic [AW-1:0] procAddr = '0;
  logic [DW-1:0] procData = '0;
  logic memWrEn, rollbackReq, checkpoint, mismatch, errHalt;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memData;

  int checks = 0;
  int errors = 0;

  // bench model: 0 first, 1 second, 2 third, 3 halted
  int mState = 0;
  logic [AW-1:0] mA0, mA1;
  logic [DW-1:0] mD0, mD1;

  always #5 clk = ~clk;

  wr_vote_top #(.ADDR_W(AW), .DATA_W(DW)) i_wr_vote_top (
    .clk(clk), .rstN(rstN), .userMode(userMode), .procWrEn(procWrEn),
    .procAddr(procAddr), .procData(procData), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .rollbackReq(rollbackReq),
    .checkpoint(checkpoint), .mismatch(mismatch), .errHalt(errHalt)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; procWrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mState = 0;
    chkEq("R1", "memWrEn", {63'd0, memWrEn}, 64'd0);
    chkEq("R1", "rollbackReq", {63'd0, rollbackReq}, 64'd0);
    chkEq("R1", "checkpoint", {63'd0, checkpoint}, 64'd0);
    chkEq("R1", "mismatch", {63'd0, mismatch}, 64'd0);
    chkEq("R1", "errHalt", {63'd0, errHalt}, 64'd0);
  endtask

  // one write through model and design, then one idle cycle
  task automatic doWrite(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic um);
    bit eWr, eRb, eCk, eMis;
    string tag;
    eWr = 0; eRb = 0; eCk = 0; eMis = 0;
    case (mState)
      0: if (um) begin
           mA0 = a; mD0 = d; eRb = 1; mState = 1; tag = "R2";
         end else begin
           eWr = 1; tag = "R7";
         end
      1: if (a == mA0 && d == mD0) begin
           eWr = 1; eCk = 1; mState = 0; tag = "R3";
         end else begin
           mA1 = a; mD1 = d; eRb = 1; eMis = 1; mState = 2; tag = "R4";
         end
      2: if ((a == mA0 && d == mD0) || (a == mA1 && d == mD1)) begin
           eWr = 1; eCk = 1; mState = 0; tag = "R5";
         end else begin
           mState = 3; tag = "R6";
         end
      default: tag = "R6";
    endcase
    @(negedge clk);
    procWrEn = 1'b1; procAddr = a; procData = d; userMode = um;
    @(negedge clk);
    procWrEn = 1'b0;
    chkEq(tag, "memWrEn", {63'd0, memWrEn}, {63'd0, eWr});
    chkEq(tag, "rollbackReq", {63'd0, rollbackReq}, {63'd0, eRb});
    chkEq(tag, "checkpoint", {63'd0, checkpoint}, {63'd0, eCk});
    chkEq(tag, "mismatch", {63'd0, mismatch}, {63'd0, eMis});
    chkEq(tag, "errHalt", {63'd0, errHalt}, {63'd0, mState == 3});
    if (eWr) begin
      chkEq(tag, "memAddr", {48'd0, memAddr}, {48'd0, a});
      chkEq(tag, "memData", {32'd0, memData}, {32'd0, d});
    end
    @(negedge clk);
    chkEq(tag, "idle memWrEn", {63'd0, memWrEn}, 64'd0);
    chkEq(tag, "idle rollbackReq", {63'd0, rollbackReq}, 64'd0);
    chkEq(tag, "idle checkpoint", {63'd0, checkpoint}, 64'd0);
    chkEq("R6", "idle errHalt", {63'd0, errHalt}, {63'd0, mState == 3});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'd4711));
    doReset();

    // directed: boot pass-through R7, clean vote R3
    doWrite(16'h0100, 32'hCAFE0001, 1'b0);
    doWrite(16'h0200, 32'h11112222, 1'b1);
    doWrite(16'h0200, 32'h11112222, 1'b1);
    // address-only difference R4, third equals first R5
    doWrite(16'h0300, 32'hAAAA5555, 1'b1);
    doWrite(16'h0301, 32'hAAAA5555, 1'b1);
    doWrite(16'h0300, 32'hAAAA5555, 1'b1);
    // data-only difference R4, third equals second R5
    doWrite(16'h0400, 32'h0000FFFF, 1'b1);
    doWrite(16'h0400, 32'h0001FFFF, 1'b1);
    doWrite(16'h0400, 32'h0001FFFF, 1'b1);
    // userMode drops mid-slice: still voted R8
    doWrite(16'h0500, 32'h12345678, 1'b1);
    doWrite(16'h0500, 32'h12345678, 1'b0);
    doWrite(16'h0600, 32'h9, 1'b0); // back in first pass, R8 then R7

    // random slices
    for (int n = 0; n < 300; n++) begin
      int kind;
      kind = $urandom % 8;
      a = AW'($urandom);
      d = $urandom;
      if (kind < 5) begin
        doWrite(a, d, 1'b1);
        doWrite(a, d, 1'b1);
      end else if (kind == 5) begin
        doWrite(a, d, 1'b1);
        doWrite(a ^ AW'(($urandom % 255) + 1), d, 1'b1);
        doWrite(a, d, 1'b1);
      end else if (kind == 6) begin
        doWrite(a, d, 1'b1);
        doWrite(a, d ^ (($urandom % 1023) + 1), 1'b1);
        doWrite(a, d ^ 32'h0, 1'b1);
        // third equal to first here also exercises R5
      end else begin
        doWrite(a, d, 1'b0);
      end
    end

    // three-way disagreement R6, then ignored writes
    doWrite(16'h0700, 32'h1, 1'b1);
    doWrite(16'h0700, 32'h2, 1'b1);
    doWrite(16'h0700, 32'h3, 1'b1);
    doWrite(16'h0700, 32'h1, 1'b1);
    doWrite(16'h0800, 32'h5, 1'b0);
    doReset();
    doWrite(16'h0900, 32'h77, 1'b1);
    doWrite(16'h0900, 32'h77, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule